// File: doc/BRIEF.md
# Shared-Adder Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit for a configurable data width (32 bits by default). It takes two operands and a three-bit function code. It returns a result word and a flag that is high when the result is all zeros. It is meant to sit in the execute stage of a simple processor datapath. There, the same function code set drives address computation, register arithmetic and branch comparison.

All arithmetic uses a single adder. The top bit of the function code does two jobs: it swaps the second operand for its bitwise complement, and it feeds the adder's carry-in. Addition and subtraction therefore share one carry chain. The two low bits of the code pick the final output from four sources: the bitwise AND, the bitwise OR, the adder output, and the adder's sign bit zero-extended to full width. The set-less-than result takes the raw sign of the difference with no overflow correction. Code 011 has no operation assigned and gives a zero result. The block has no clock, so results follow the inputs within the same cycle.

Top module: `shared_adder_alu`

## Requirements
- R1: Function code 000 returns the bitwise AND of the operands, and code 001 returns their bitwise OR.
- R2: Function code 010 returns the sum of the operands modulo 2^WIDTH.
- R3: Function code 100 returns A AND (NOT B), and code 101 returns A OR (NOT B).
- R4: Function code 110 returns A minus B modulo 2^WIDTH, computed as A plus the complement of B plus a carry-in of one.
- R5: Function code 111 returns a word whose bits WIDTH-1 down to 1 are zero and whose bit 0 is the most significant bit of A minus B (modulo 2^WIDTH). There is no overflow correction, so A=0x7FFFFFFF with B=0xFFFFFFFF gives 1.
- R6: Function code 011 returns an all-zero result.
- R7: The zero flag is 1 exactly when every bit of the result is 0. This holds for every function code, including 011.
- R8: The result and the flag depend only on the present inputs, with no clock and no stored state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand (complemented when code bit 2 is 1) |
| func_i | input | 3 | Function code; bit 2 selects complement and carry-in, bits 1:0 select the output source |
| y_o | output | WIDTH | Result word |
| zero_o | output | 1 | High when y_o is all zeros |

## Verification
Two functions meet in one evaluation: the zero flag and the comparison or subtraction result. Any subtraction of equal operands produces a zero difference and must raise the flag. Any set-less-than whose difference is non-negative yields a zero word and must also raise the flag. The bench provokes these by sweeping every function code over the cross product of a corner operand set: zero, one, all ones, the sign bit alone, the largest positive value, and alternating patterns. This set includes equal pairs and pairs whose difference overflows. Each result and flag is judged against an arithmetic model. That model reproduces the uncorrected sign bit for set-less-than.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int FUNC_W = 3;

  // Output source selected by function code bits 1:0
  typedef enum logic [1:0] {
    SRC_AND = 2'b00,
    SRC_OR  = 2'b01,
    SRC_SUM = 2'b10,
    SRC_SGN = 2'b11
  } out_src_e;

  localparam logic [FUNC_W-1:0] FUNC_UNUSED = 3'b011;
endpackage

// File: rtl/alu_operand_prep.sv
module alu_operand_prep #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] b_i,
  input  logic             inv_i,
  output logic [WIDTH-1:0] b_eff_o
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  // XOR with a replicated select: one gate level per bit
  assign b_eff_o = b_i ^ (inv_i ? ALL_ONES : '0);

  always_comb begin
    if (!$isunknown({b_i, inv_i})) begin
      assert_complement_R3: assert (inv_i ? ((b_eff_o & b_i) == '0) : (b_eff_o == b_i))
        else $error("operand conditioning mismatch");
    end
  end
endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o
);
  localparam logic [WIDTH-1:0] CIN_ZERO = '0;

  logic [WIDTH-1:0] cin_word;
  assign cin_word = {CIN_ZERO[WIDTH-1:1], cin_i};
  assign sum_o    = a_i + b_i + cin_word;
endmodule

// File: rtl/alu_result_sel.sv
module alu_result_sel
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  out_src_e         src_i,
  input  logic             kill_i,
  input  logic [WIDTH-1:0] and_i,
  input  logic [WIDTH-1:0] or_i,
  input  logic [WIDTH-1:0] sum_i,
  output logic [WIDTH-1:0] y_o,
  output logic             zero_o
);
  localparam int UPPER = WIDTH - 1;

  logic [WIDTH-1:0] picked;
  logic [WIDTH-1:0] sign_word;

  assign sign_word = {{UPPER{1'b0}}, sum_i[WIDTH-1]};

  always_comb begin
    unique case (src_i)
      SRC_AND: picked = and_i;
      SRC_OR:  picked = or_i;
      SRC_SUM: picked = sum_i;
      default: picked = sign_word;
    endcase
  end

  assign y_o    = kill_i ? '0 : picked;
  assign zero_o = ~|y_o;

  always_comb begin
    if (!$isunknown({src_i, kill_i, and_i, or_i, sum_i})) begin
      assert_zero_flag_R7: assert (!zero_o || (picked == '0) || kill_i)
        else $error("zero flag raised on non-zero source");
      assert_kill_R6: assert (!kill_i || zero_o)
        else $error("unused code did not clear the result");
    end
  end
endmodule

// File: rtl/shared_adder_alu.sv
module shared_adder_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0]  a_i,
  input  logic [WIDTH-1:0]  b_i,
  input  logic [FUNC_W-1:0] func_i,
  output logic [WIDTH-1:0]  y_o,
  output logic              zero_o
);
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH-1:0] sum;
  logic [WIDTH-1:0] and_w;
  logic [WIDTH-1:0] or_w;
  logic             inv;
  logic             kill;
  out_src_e         src;

  assign inv  = func_i[2];
  assign kill = (func_i == FUNC_UNUSED);
  assign src  = out_src_e'(func_i[1:0]);

  alu_operand_prep #(.WIDTH(WIDTH)) u_prep (
    .b_i     (b_i),
    .inv_i   (inv),
    .b_eff_o (b_eff)
  );

  alu_adder #(.WIDTH(WIDTH)) u_add (
    .a_i   (a_i),
    .b_i   (b_eff),
    .cin_i (inv),
    .sum_o (sum)
  );

  assign and_w = a_i & b_eff;
  assign or_w  = a_i | b_eff;

  alu_result_sel #(.WIDTH(WIDTH)) u_sel (
    .src_i  (src),
    .kill_i (kill),
    .and_i  (and_w),
    .or_i   (or_w),
    .sum_i  (sum),
    .y_o    (y_o),
    .zero_o (zero_o)
  );

  always_comb begin
    if (!$isunknown({a_i, b_i, func_i})) begin
      if (func_i == 3'b000)
        assert_and_subset_R1: assert ((y_o & ~a_i) == '0) else $error("AND exceeds operand A");
      if (func_i == 3'b010)
        assert_add_inverse_R2: assert ((y_o - b_i) == a_i) else $error("sum does not invert");
      if (func_i == 3'b100)
        assert_andnot_R3: assert ((y_o & b_i) == '0) else $error("AND-NOT overlaps B");
      if (func_i == 3'b110)
        assert_sub_inverse_R4: assert ((y_o + b_i) == a_i) else $error("difference does not invert");
      if (func_i == 3'b111)
        assert_slt_extend_R5: assert (y_o[WIDTH-1:1] == '0) else $error("set-less-than not zero-extended");
      if (func_i == FUNC_UNUSED)
        assert_unused_code_R6: assert (y_o == '0) else $error("unused code not zero");
    end
  end
endmodule

// File: tb/test_shared_adder_alu.sv
module test_shared_adder_alu;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a, b;
  logic [2:0]   f;
  logic [W-1:0] y;
  logic         zero;
  int           total = 0;
  int           bad = 0;
  bit           done = 1'b0;

  always #5 clk = ~clk;

  shared_adder_alu #(.WIDTH(W)) i_shared_adder_alu (
    .a_i(a), .b_i(b), .func_i(f), .y_o(y), .zero_o(zero)
  );

  function automatic logic [W-1:0] model(input logic [W-1:0] x, input logic [W-1:0] z,
                                         input logic [2:0] c);
    logic [W-1:0] d;
    d = x - z;
    case (c)
      3'b000: return x & z;
      3'b001: return x | z;
      3'b010: return x + z;
      3'b100: return x & ~z;
      3'b101: return x | ~z;
      3'b110: return d;
      3'b111: return {{(W-1){1'b0}}, d[W-1]};
      default: return '0;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] c);
    case (c)
      3'b000, 3'b001: return "R1";
      3'b010: return "R2";
      3'b100, 3'b101: return "R3";
      3'b110: return "R4";
      3'b111: return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic logic [W-1:0] corner(input int k);
    case (k)
      0: return '0;
      1: return 32'h0000_0001;
      2: return '1;
      3: return 32'h8000_0000;
      4: return 32'h7FFF_FFFF;
      5: return 32'hAAAA_AAAA;
      6: return 32'h5555_5555;
      default: return 32'h0000_FFFF;
    endcase
  endfunction

  task automatic apply_and_check(input logic [W-1:0] x, input logic [W-1:0] z,
                                 input logic [2:0] c);
    logic [W-1:0] e;
    @(posedge clk);
    a = x; b = z; f = c;
    @(negedge clk);
    e = model(x, z, c);
    total++;
    if (y !== e) begin
      bad++;
      $display("FAIL %s code=%b a=%h b=%h y=%h expected=%h", tag_of(c), c, x, z, y, e);
    end
    total++;
    if (zero !== (e == '0)) begin
      bad++;
      $display("FAIL R7 code=%b a=%h b=%h zero=%b expected=%b", c, x, z, zero, (e == '0));
    end
  endtask

  initial begin
    logic [31:0] lfsr;
    a = '0; b = '0; f = 3'b000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // Reset-time state with zero inputs: AND of zeros, flag high (R7, R8)
    total++;
    if (y !== '0 || zero !== 1'b1) begin
      bad++;
      $display("FAIL R7 idle y=%h zero=%b expected=0 1", y, zero);
    end
    rst = 1'b0;
    // Corner sweep, all codes (R1..R7)
    for (int c = 0; c < 8; c++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          apply_and_check(corner(i), corner(j), 3'(c));
    // Overflowed set-less-than expects raw sign (R5)
    apply_and_check(32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b111);
    apply_and_check(32'h8000_0000, 32'h0000_0001, 3'b111);
    // Input change reflected same cycle without state (R8)
    apply_and_check(32'h0000_0005, 32'h0000_0005, 3'b110);
    apply_and_check(32'h0000_0005, 32'h0000_0003, 3'b110);
    // Pseudo-random operands
    lfsr = 32'hACE1_2345;
    for (int n = 0; n < 200; n++) begin
      logic [W-1:0] ra, rb;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      ra = lfsr;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      rb = lfsr;
      for (int c = 0; c < 8; c++) apply_and_check(ra, rb, 3'(c));
    end
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL R8 watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule